// File: doc/BRIEF.md
# Zero-Turnaround Synchronous Static RAM

This block is a synthesizable behavioural model of a synchronous static RAM with 18-bit words. It is organised as two 9-bit bytes, and each byte carries its own parity position. Commands are registered on the rising clock edge. A command is either a fresh load, which takes a new address and a direction, or a burst step, which advances a two-bit counter inside a four-word block.

Both reads and writes use the data bus in the cycle after their command. The read word flows combinationally from the registered address to `dout`. The write word is sampled on `din` at the following edge. Because of this, a write can be followed by a read, or a read by a write, on consecutive cycles without any idle cycle. A write does not reach the array at once. It waits in a one-entry holding stage and is committed on the next active edge. Reads that hit the held entry take those bytes from the holding stage instead of the array.

A high clock-enable freezes every register, as if that edge never happened. The array contents are not cleared by reset.

Top module: `zt_sram`

## Requirements
- R1: A new command is accepted on a rising edge only when `cke_n` is 0, `load_n` is 0 and all three selects are true (`cs1_n`=0, `cs2`=1, `cs3_n`=0). The command targets word `addr`, and it is a write when `wr_n` is 0.
- R2: After a read is accepted, `dout_vld` is 1 during the next cycle and `dout` shows the word at the target address.
- R3: After a write is accepted, the value on `din` at the next active edge is stored at the target address.
- R4: `be_n[0]`=0 enables bits 8:0 and `be_n[1]`=0 enables bits 17:9. Byte enables are sampled with every write command and burst step, and a disabled byte keeps its old value. Reads ignore the byte enables: a read never alters the array, whatever `be_n` holds.
- R5: With `load_n`=1 after an active command, the two low address bits increment modulo 4 while the upper bits stay fixed. The direction set at the load is kept.
- R6: A load with any select false deselects the block. `dout_vld` goes to 0, later burst steps stay deselected, and nothing is written.
- R7: With `cke_n`=1 at an edge, every other input is ignored and `dout` and `dout_vld` keep their values.
- R8: A read issued right after a write to the same address returns the newly written bytes merged with the unwritten ones.
- R9: `dout_vld` is 0 after reset and in any cycle that follows an accepted write command.
- R10: Reads and writes to arbitrary addresses may alternate on every cycle, and each one still returns or stores the correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline registers |
| cke_n | input | 1 | Active-low clock enable; high stalls the whole block |
| cs1_n | input | 1 | Active-low select |
| cs2 | input | 1 | Active-high select |
| cs3_n | input | 1 | Active-low select |
| load_n | input | 1 | 0 loads a new command, 1 steps the burst |
| wr_n | input | 1 | Direction on a load: 0 write, 1 read |
| be_n | input | 2 | Active-low byte write enables |
| addr | input | ADDR_W | Word address |
| din | input | 18 | Write data, one cycle after its command |
| dout | output | 18 | Flow-through read data |
| dout_vld | output | 1 | Read data valid (0 models a high-impedance bus) |

## Verification
The assertions check the following on every cycle:
- a qualified load captures the address and direction;
- a burst step increments only the low two bits;
- a deselecting load clears the active state;
- a stall freezes the command register and the valid flag;
- a write command always leaves the data bus invalid in the next cycle;
- a full-word hit in the holding stage drives `dout` from it.

Only the bench's scenarios can show that the correct data actually lands in the array. This covers byte merging across partial writes, wrap-around burst order, the fact that writes are suppressed while deselected, and data integrity under long random interleavings with stalls mixed in.

// File: rtl/zt_pkg.sv
`timescale 1ns/1ps
package zt_pkg;
  localparam int BYTE_W  = 9;
  localparam int NBYTES  = 2;
  localparam int WORD_W  = BYTE_W * NBYTES;
  localparam int BURST_W = 2;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [NBYTES-1:0] ben_t;
endpackage

// File: rtl/zt_cmd_stage.sv
`timescale 1ns/1ps
module zt_cmd_stage
  import zt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_n,
  input  logic              load_n,
  input  logic              sel_ok,
  input  logic              wr_n,
  input  ben_t              be_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              act,
  output logic              is_wr,
  output ben_t              be,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic               act_q, act_d;
  logic               wr_q, wr_d;
  ben_t               be_q, be_d;
  logic [HI_W-1:0]    base_q, base_d;
  logic [BURST_W-1:0] cnt_q, cnt_d;
  logic               step_en;

  assign step_en = !cke_n;

  // next-state: load, deselect or burst step
  always_comb begin
    act_d  = act_q;
    wr_d   = wr_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    be_d   = ~be_n;
    if (!load_n) begin
      if (sel_ok) begin
        act_d  = 1'b1;
        wr_d   = !wr_n;
        base_d = addr[ADDR_W-1:BURST_W];
        cnt_d  = addr[BURST_W-1:0];
      end else begin
        act_d  = 1'b0;
      end
    end else if (act_q) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      be_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (step_en) begin
      act_q  <= act_d;
      wr_q   <= wr_d;
      be_q   <= be_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
    end
  end

  assign act      = act_q;
  assign is_wr    = wr_q;
  assign be       = be_q;
  assign cur_addr = {base_q, cnt_q};

  // R1: qualified load captures address and direction
  a_r1_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !load_n && sel_ok) |=> (act_q && cur_addr == $past(addr) && wr_q == !$past(wr_n)));

  // R5: burst step walks the low bits, keeps block and direction
  a_r5_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && load_n && act_q) |=> (cnt_q == $past(cnt_q) + 2'd1 && $stable(base_q) && $stable(wr_q)));

  // R6: load with a false select deselects
  a_r6_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !load_n && !sel_ok) |=> !act_q);

  // R7: stalled edge leaves the command register untouched
  a_r7_stall_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> ($stable(act_q) && $stable(cur_addr) && $stable(wr_q) && $stable(be_q)));
endmodule

// File: rtl/zt_wbuf.sv
`timescale 1ns/1ps
module zt_wbuf
  import zt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_n,
  input  logic              cmd_act,
  input  logic              cmd_wr,
  input  ben_t              cmd_be,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  word_t             din,
  output logic              wp_vld,
  output logic [ADDR_W-1:0] wp_addr,
  output word_t             wp_data,
  output ben_t              wp_be
);
  logic              vld_q, vld_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  word_t             data_q, data_d;
  ben_t              be_q, be_d;
  logic              take;
  logic              step_en;

  assign step_en = !cke_n;
  assign take    = cmd_act && cmd_wr && (|cmd_be);

  always_comb begin
    vld_d  = take;
    addr_d = addr_q;
    data_d = data_q;
    be_d   = be_q;
    if (take) begin
      addr_d = cmd_addr;
      data_d = din;
      be_d   = cmd_be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      be_q   <= '0;
    end else if (step_en) begin
      vld_q  <= vld_d;
      addr_q <= addr_d;
      data_q <= data_d;
      be_q   <= be_d;
    end
  end

  assign wp_vld  = vld_q;
  assign wp_addr = addr_q;
  assign wp_data = data_q;
  assign wp_be   = be_q;

  // R3: write data sampled one active edge after the command
  a_r3_late_data: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && cmd_act && cmd_wr && (|cmd_be)) |=>
      (wp_vld && wp_data == $past(din) && wp_addr == $past(cmd_addr)));

  // R7: stall keeps the holding stage
  a_r7_stall_wbuf: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> ($stable(wp_vld) && $stable(wp_addr) && $stable(wp_be)));
endmodule

// File: rtl/zt_mem.sv
`timescale 1ns/1ps
module zt_mem
  import zt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wr_addr,
  input  word_t             wr_data,
  input  ben_t              wr_be,
  input  logic [ADDR_W-1:0] rd_addr,
  output word_t             rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  word_t mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (wr_be[b]) mem_q[wr_addr][b*BYTE_W +: BYTE_W] <= wr_data[b*BYTE_W +: BYTE_W];
      end
    end
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/zt_sram.sv
`timescale 1ns/1ps
module zt_sram
  import zt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke_n,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              cs3_n,
  input  logic              load_n,
  input  logic              wr_n,
  input  logic [1:0]        be_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [17:0]       din,
  output logic [17:0]       dout,
  output logic              dout_vld
);
  logic              sel_ok;
  logic              cmd_act, cmd_wr;
  ben_t              cmd_be;
  logic [ADDR_W-1:0] cmd_addr;
  logic              wp_vld;
  logic [ADDR_W-1:0] wp_addr;
  word_t             wp_data;
  ben_t              wp_be;
  word_t             rd_data;
  logic              commit_en;
  ben_t              hit;

  assign sel_ok = !cs1_n && cs2 && !cs3_n;

  zt_cmd_stage #(.ADDR_W(ADDR_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .load_n(load_n), .sel_ok(sel_ok),
    .wr_n(wr_n), .be_n(be_n), .addr(addr),
    .act(cmd_act), .is_wr(cmd_wr), .be(cmd_be), .cur_addr(cmd_addr)
  );

  zt_wbuf #(.ADDR_W(ADDR_W)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cmd_act(cmd_act), .cmd_wr(cmd_wr),
    .cmd_be(cmd_be), .cmd_addr(cmd_addr), .din(din),
    .wp_vld(wp_vld), .wp_addr(wp_addr), .wp_data(wp_data), .wp_be(wp_be)
  );

  assign commit_en = !cke_n && wp_vld;

  zt_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(commit_en), .wr_addr(wp_addr), .wr_data(wp_data), .wr_be(wp_be),
    .rd_addr(cmd_addr), .rd_data(rd_data)
  );

  // per-byte forwarding from the holding stage
  for (genvar gb = 0; gb < NBYTES; gb++) begin : g_fwd
    localparam int LO = gb * BYTE_W;
    assign hit[gb] = wp_vld && (wp_addr == cmd_addr) && wp_be[gb];
    assign dout[LO +: BYTE_W] = hit[gb] ? wp_data[LO +: BYTE_W] : rd_data[LO +: BYTE_W];
  end

  assign dout_vld = cmd_act && !cmd_wr;

  // R2: accepted read drives valid data next cycle
  a_r2_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !load_n && sel_ok && wr_n) |=> dout_vld);

  // R9: bus idle after an accepted write
  a_r9_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !load_n && sel_ok && !wr_n) |=> !dout_vld);

  // R8: full-word hit reads the freshly written word
  a_r8_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_vld && wp_vld && wp_addr == cmd_addr && (&wp_be)) |-> (dout == wp_data));

  // R7: valid flag holds across a stall
  a_r7_stall_vld: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> $stable(dout_vld));
endmodule

// File: tb/zt_sram_tb.sv
`timescale 1ns/1ps
module zt_sram_tb;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk, rst_n, cke_n, cs1_n, cs2, cs3_n, load_n, wr_n;
  logic [1:0]    be_n;
  logic [AW-1:0] addr;
  logic [17:0]   din, dout;
  logic          dout_vld;

  int    checks = 0, failures = 0;
  string cur_req = "R9";
  bit    done = 0;

  // reference model state
  logic [17:0] mem_m [DEPTH];
  bit   [1:0]  kn [DEPTH];
  bit          m_act, m_wr;
  bit   [1:0]  m_be;
  int          m_addr;

  zt_sram #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
    .load_n(load_n), .wr_n(wr_n), .be_n(be_n), .addr(addr), .din(din),
    .dout(dout), .dout_vld(dout_vld)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  initial begin
    for (int i = 0; i < DEPTH; i++) kn[i] = 2'b00;
    m_act = 0; m_wr = 0; m_be = 0; m_addr = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_wr = 0; m_be = 0; m_addr = 0;
    end else if (!cke_n) begin
      if (m_act && m_wr) begin
        for (int b = 0; b < 2; b++) if (m_be[b]) begin
          mem_m[m_addr][b*9 +: 9] = din[b*9 +: 9];
          kn[m_addr][b] = 1'b1;
        end
      end
      if (!load_n) begin
        if (!cs1_n && cs2 && !cs3_n) begin
          m_act = 1; m_addr = int'(addr); m_wr = !wr_n;
        end else m_act = 0;
      end else if (m_act) begin
        m_addr = (m_addr & ~3) | ((m_addr + 1) & 3);
      end
      m_be = ~be_n;
    end
  end

  task automatic compare();
    bit exp_vld;
    bit bad;
    exp_vld = m_act && !m_wr;
    checks++;
    bad = (dout_vld !== exp_vld);
    if (!bad && exp_vld) begin
      for (int b = 0; b < 2; b++)
        if (kn[m_addr][b] && dout[b*9 +: 9] !== mem_m[m_addr][b*9 +: 9]) bad = 1;
    end
    if (bad) begin
      failures++;
      $display("FAIL %s: vld=%0b dout=%h expected vld=%0b dout=%h (addr %0d)",
               cur_req, dout_vld, dout, exp_vld, exp_vld ? mem_m[m_addr] : 18'h0, m_addr);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  // cs = {cs3_n, cs2, cs1_n}; 3'b010 selects the block
  task automatic cyc(input logic ld, input logic w, input int a, input logic [1:0] ben,
                     input logic [17:0] d, input logic [2:0] cs = 3'b010);
    cke_n = 0; load_n = ld; wr_n = w; addr = a[AW-1:0]; be_n = ben; din = d;
    {cs3_n, cs2, cs1_n} = cs;
    tick();
  endtask

  task automatic stall(input int n);
    for (int i = 0; i < n; i++) begin
      cke_n = 1; load_n = 1'($urandom); wr_n = 1'($urandom); addr = AW'($urandom);
      be_n = 2'($urandom); din = 18'($urandom);
      tick();
    end
  endtask

  initial begin
    rst_n = 0; cke_n = 0; cs1_n = 0; cs2 = 1; cs3_n = 0; load_n = 1; wr_n = 1;
    be_n = 0; addr = 0; din = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    checks++;
    if (dout_vld !== 1'b0) begin
      failures++; $display("FAIL R9: reset dout_vld=%0b expected 0", dout_vld);
    end
    rst_n = 1;
    tick();

    // R3 / R5: burst write from 16, data one cycle late
    cur_req = "R3";
    cyc(0, 0, 16, 2'b00, 18'h0);
    cyc(1, 0, 0, 2'b00, 18'h11111);
    cyc(1, 0, 0, 2'b00, 18'h22222);
    cyc(1, 0, 0, 2'b00, 18'h33333);
    cur_req = "R2";
    cyc(0, 1, 16, 2'b00, 18'h04444);
    cyc(1, 1, 0, 2'b00, 18'h0);
    cyc(1, 1, 0, 2'b00, 18'h0);
    cyc(1, 1, 0, 2'b00, 18'h0);
    // R5: wrap from 18
    cur_req = "R5";
    cyc(0, 1, 18, 2'b11, 18'h0);
    cyc(1, 1, 0, 2'b11, 18'h0);
    cyc(1, 1, 0, 2'b11, 18'h0);
    cyc(1, 1, 0, 2'b11, 18'h0);
    cyc(1, 1, 0, 2'b11, 18'h0);
    // R4: byte enables per cycle, full words first then partial
    cur_req = "R4";
    cyc(0, 0, 40, 2'b00, 18'h0);
    cyc(1, 0, 0, 2'b00, 18'h3ffff);
    cyc(1, 0, 0, 2'b10, 18'h2aaaa);
    cyc(0, 0, 40, 2'b01, 18'h15555);
    cyc(0, 0, 40, 2'b10, 18'h0f0f0);
    cyc(0, 1, 40, 2'b11, 18'h0a5a5);
    cyc(0, 1, 41, 2'b00, 18'h0);
    cyc(0, 1, 40, 2'b00, 18'h0);
    cyc(0, 1, 40, 2'b00, 18'h0);
    // R8: read right behind a write to the same address
    cur_req = "R8";
    cyc(0, 0, 60, 2'b00, 18'h0);
    cyc(0, 1, 60, 2'b00, 18'h1c3c3);
    cyc(0, 0, 60, 2'b01, 18'h0);
    cyc(0, 1, 60, 2'b11, 18'h2dddd);
    cyc(0, 1, 60, 2'b00, 18'h0);
    // R10: alternate every cycle
    cur_req = "R10";
    for (int i = 0; i < 8; i++) begin
      cyc(0, 0, 70 + i, 2'b00, 18'(i * 4097 + 5));
      cyc(0, 1, 70 + (i / 2), 2'b00, 18'(i * 3001 + 9));
    end
    cyc(0, 1, 77, 2'b00, 18'h0);
    // R6: deselect through each select pin
    cur_req = "R6";
    cyc(0, 1, 16, 2'b00, 18'h0);
    cyc(0, 0, 16, 2'b00, 18'h0, 3'b011);
    cyc(1, 0, 0, 2'b00, 18'h3aaaa);
    cyc(1, 1, 0, 2'b00, 18'h15151);
    cyc(0, 1, 17, 2'b00, 18'h0, 3'b000);
    cyc(0, 1, 17, 2'b00, 18'h0, 3'b110);
    cyc(0, 1, 16, 2'b00, 18'h0);
    cyc(1, 1, 0, 2'b00, 18'h0);
    // R7: stalls during a read burst and between write and its data
    cur_req = "R7";
    cyc(0, 1, 40, 2'b00, 18'h0);
    stall(3);
    cyc(1, 1, 0, 2'b00, 18'h0);
    cyc(0, 0, 90, 2'b00, 18'h0);
    stall(2);
    cyc(0, 1, 90, 2'b00, 18'h12345);
    stall(2);
    cyc(1, 1, 0, 2'b00, 18'h0);
    // R1: load only when qualified; random mix
    cur_req = "R1";
    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom % 100);
      if (r < 8) stall(1);
      else cyc(1'($urandom % 4 == 0), 1'($urandom), int'($urandom % 12),
               2'($urandom), 18'($urandom), (r < 14) ? 3'($urandom) : 3'b010);
    end
    cur_req = "R9";
    cyc(0, 0, 5, 2'b00, 18'h0);
    cyc(1, 1, 0, 2'b00, 18'h01010);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule